// File: doc/BRIEF.md
# Dual-Bank Flash and SRAM Memory

This block is a cycle-level model of one memory device that holds two byte-wide banks behind a single bus. One bank is a flash array with a built-in program and erase engine. The other is a plain SRAM. Both banks see the same address, write data, write strobe and read strobe. Each bank has its own active-low select, and that select decides which bank a bus cycle reaches. A bus cycle lasts one clock. A write is a cycle with the write strobe low. A read is a cycle with the read strobe low and the write strobe high. Read data appears on `dataOut` one clock after the read cycle.

Writes to the flash never change its contents directly. They feed an unlock sequencer. When a complete command sequence arrives, the sequencer latches the target address and data and starts a byte program, a sector erase or a whole-array erase. The operation then runs for a parameterised number of cycles with no further bus activity. While it runs, flash reads return a status byte instead of array data. The SRAM stays fully usable the whole time.

The default geometry is deliberately small: a 1 KB flash in 256-byte sectors and a 512-byte SRAM, so that the model elaborates quickly. The full-size device uses `FLASH_AW=18`, `SECT_AW=12` and `SRAM_AW=17`. The default busy counts are also scaled down. The full-size values follow the clock rate: 14 µs for a byte program, 18 ms for a sector erase and 70 ms for a whole-array erase, and a byte program must never exceed 20 µs.

Top module: `dbm_top`

## Requirements
- R1: A cycle with `sramSelN`=0 and `flashSelN`=1 reaches only the SRAM, and a cycle with `flashSelN`=0 and `sramSelN`=1 reaches only the flash. Data from a read cycle is on `dataOut` after the next rising edge. After any cycle that is not a read, `dataOut` is 0x00.
- R2: A cycle with both selects low is ignored. It writes nothing, and `dataOut` is 0x00 afterwards.
- R3: SRAM writes and reads work normally while a flash operation is busy, including in the cycle in which the operation completes.
- R4: A flash write that is not part of a complete unlock sequence leaves the flash contents unchanged.
- R5: Byte program is unlocked by writes of 0xAA to 0x5555, 0x55 to 0x2AAA and 0xA0 to 0x5555. The next flash write gives the target address and data. Programming can only clear bits: the stored byte becomes the old byte AND the new data.
- R6: Sector erase uses the sequence 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, followed by 0x30 to any address in the target sector. Every byte of that sector becomes 0xFF, and other sectors keep their contents. The sector number is address bits [FLASH_AW-1:SECT_AW].
- R7: The same five-write prefix followed by 0x10 written to 0x5555 erases the whole flash to 0xFF. A 0x10 written to any other address starts nothing. The SRAM is unaffected.
- R8: A flash write that does not match the next expected step of a sequence returns the sequencer to idle, and no operation starts.
- R9: A flash write that arrives while an operation is busy is ignored. It does not change the running operation, and it leaves the sequencer idle.
- R10: After the cycle that starts an operation, flash reads return status for exactly PROG_CYCLES, SECT_CYCLES or BANK_CYCLES cycles, depending on the operation. After that, they return array data. A program never stays busy for PROG_MAX_CYCLES cycles or more.
- R11: In the status byte, bit 6 is 0 on the first read after a start and inverts on each later flash read while busy. Bits 5..0 are 0.
- R12: Status bit 7 is the inverse of bit 7 of the data being programmed during a program, and 0 during an erase.
- R13: After reset, `dataOut` is 0x00, no operation is busy, and every flash byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | BUS_AW | Shared byte address (BUS_AW is the largest of 15, FLASH_AW and SRAM_AW) |
| dataIn | input | 8 | Shared write data |
| dataOut | output | 8 | Registered read data or flash status |
| wrStrobeN | input | 1 | Shared active-low write strobe |
| rdStrobeN | input | 1 | Shared active-low read strobe |
| flashSelN | input | 1 | Active-low flash bank select |
| sramSelN | input | 1 | Active-low SRAM bank select |

## Verification
The bench makes two events fall on one clock edge. It starts a byte program, counts PROG_CYCLES edges from the starting write, and lands an SRAM write exactly on the edge where the program timer expires and the flash array is updated. It then reads back the SRAM byte and the programmed flash byte. Both must hold their new values, which shows that the program commit and the SRAM write did not block or corrupt each other. A second case delivers a full unlock-and-program sequence in the middle of a busy window. The original target must still get its data, and the second target must still read 0xFF.

// File: rtl/dbm_pkg.sv
package dbm_pkg;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_PROG,
    OP_SECT,
    OP_BANK
  } flashOp_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_KEY1,
    SQ_KEY2,
    SQ_PROG_ARMED,
    SQ_ERASE_ARMED,
    SQ_ERASE_KEY1,
    SQ_ERASE_KEY2
  } seqState_e;

  // Control to datapath strobes
  typedef struct packed {
    logic     commit;      // apply the latched operation to the array this edge
    flashOp_e op;          // operation in flight
    logic     busy;        // flash engine running
    logic     statusBit7;  // polling bit
    logic     statusBit6;  // toggle bit
  } flashStrobe_t;

  localparam logic [14:0] CMD_ADDR_A = 15'h5555;
  localparam logic [14:0] CMD_ADDR_B = 15'h2AAA;
  localparam logic [7:0]  KEY_FIRST  = 8'hAA;
  localparam logic [7:0]  KEY_SECOND = 8'h55;
  localparam logic [7:0]  CMD_PROG   = 8'hA0;
  localparam logic [7:0]  CMD_ERASE  = 8'h80;
  localparam logic [7:0]  CMD_SECT   = 8'h30;
  localparam logic [7:0]  CMD_BANK   = 8'h10;

endpackage

// File: rtl/dbm_ctrl.sv
module dbm_ctrl
  import dbm_pkg::*;
#(
  parameter int BUS_AW      = 15,
  parameter int FLASH_AW    = 10,
  parameter int PROG_CYCLES = 12,
  parameter int SECT_CYCLES = 40,
  parameter int BANK_CYCLES = 60
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [BUS_AW-1:0]   addr,
  input  logic [7:0]          dataIn,
  input  logic                wrStrobeN,
  input  logic                rdStrobeN,
  input  logic                flashSelN,
  input  logic                sramSelN,
  output flashStrobe_t        strobe,
  output logic [FLASH_AW-1:0] latAddr,
  output logic [7:0]          latData
);

  localparam int MAX_ERASE = (BANK_CYCLES > SECT_CYCLES) ? BANK_CYCLES : SECT_CYCLES;
  localparam int MAX_CYC   = (MAX_ERASE > PROG_CYCLES) ? MAX_ERASE : PROG_CYCLES;
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  seqState_e        seqState, seqNext;
  flashOp_e         startOp, curOp;
  logic             busy, toggle;
  logic [CNT_W-1:0] cnt, loadVal;
  logic             flashWr, flashRd, atA, atB;

  assign flashWr = !wrStrobeN && !flashSelN && sramSelN;
  assign flashRd = !rdStrobeN && wrStrobeN && !flashSelN && sramSelN;
  assign atA     = (addr[14:0] == CMD_ADDR_A);
  assign atB     = (addr[14:0] == CMD_ADDR_B);

  // Unlock sequencer: any flash write leaves the sequencer in idle unless it is the exact next step
  always_comb begin
    seqNext = seqState;
    startOp = OP_NONE;
    if (flashWr) begin
      seqNext = SQ_IDLE;
      if (!busy) begin
        case (seqState)
          SQ_IDLE:  if (atA && dataIn == KEY_FIRST) seqNext = SQ_KEY1;
          SQ_KEY1:  if (atB && dataIn == KEY_SECOND) seqNext = SQ_KEY2;
          SQ_KEY2: begin
            if (atA && dataIn == CMD_PROG) seqNext = SQ_PROG_ARMED;
            else if (atA && dataIn == CMD_ERASE) seqNext = SQ_ERASE_ARMED;
          end
          SQ_PROG_ARMED:  startOp = OP_PROG;
          SQ_ERASE_ARMED: if (atA && dataIn == KEY_FIRST) seqNext = SQ_ERASE_KEY1;
          SQ_ERASE_KEY1:  if (atB && dataIn == KEY_SECOND) seqNext = SQ_ERASE_KEY2;
          SQ_ERASE_KEY2: begin
            if (dataIn == CMD_SECT) startOp = OP_SECT;
            else if (atA && dataIn == CMD_BANK) startOp = OP_BANK;
          end
          default: seqNext = SQ_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    case (startOp)
      OP_PROG: loadVal = CNT_W'(PROG_CYCLES - 1);
      OP_SECT: loadVal = CNT_W'(SECT_CYCLES - 1);
      OP_BANK: loadVal = CNT_W'(BANK_CYCLES - 1);
      default: loadVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqState <= SQ_IDLE;
      busy     <= 1'b0;
      cnt      <= '0;
      curOp    <= OP_NONE;
      latAddr  <= '0;
      latData  <= '0;
      toggle   <= 1'b0;
    end else begin
      seqState <= seqNext;
      if (startOp != OP_NONE) begin
        busy    <= 1'b1;
        curOp   <= startOp;
        latAddr <= addr[FLASH_AW-1:0];
        latData <= dataIn;
        toggle  <= 1'b0;
        cnt     <= loadVal;
      end else if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else           cnt  <= cnt - 1'b1;
        if (flashRd) toggle <= ~toggle;
      end
    end
  end

  always_comb begin
    strobe.commit     = busy && (cnt == '0);
    strobe.op         = curOp;
    strobe.busy       = busy;
    strobe.statusBit7 = (curOp == OP_PROG) ? ~latData[7] : 1'b0;
    strobe.statusBit6 = toggle;
  end

endmodule

// File: rtl/dbm_datapath.sv
module dbm_datapath
  import dbm_pkg::*;
#(
  parameter int FLASH_AW = 10,
  parameter int SECT_AW  = 8,
  parameter int SRAM_AW  = 9
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [FLASH_AW-1:0] flashIdx,
  input  logic [SRAM_AW-1:0]  sramIdx,
  input  logic [7:0]          dataIn,
  input  logic                wrStrobeN,
  input  logic                rdStrobeN,
  input  logic                flashSelN,
  input  logic                sramSelN,
  input  flashStrobe_t        strobe,
  input  logic [FLASH_AW-1:0] latAddr,
  input  logic [7:0]          latData,
  output logic [7:0]          dataOut
);

  localparam int FLASH_DEPTH = 1 << FLASH_AW;
  localparam int SRAM_DEPTH  = 1 << SRAM_AW;
  localparam int NUM_SECT    = 1 << (FLASH_AW - SECT_AW);

  logic [7:0] flashMem [FLASH_DEPTH];
  logic [7:0] sramMem  [SRAM_DEPTH];
  logic [NUM_SECT-1:0] sectHit;
  logic sramWr, sramRd, flashRd;

  assign sramWr  = !wrStrobeN && !sramSelN && flashSelN;
  assign sramRd  = !rdStrobeN && wrStrobeN && !sramSelN && flashSelN;
  assign flashRd = !rdStrobeN && wrStrobeN && !flashSelN && sramSelN;

  // One erase-enable per sector
  for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
    assign sectHit[s] = (strobe.op == OP_BANK) ||
                        ((strobe.op == OP_SECT) &&
                         (latAddr[FLASH_AW-1:SECT_AW] == (FLASH_AW - SECT_AW)'(s)));
  end

  always_ff @(posedge clk) begin
    if (sramWr) sramMem[sramIdx] <= dataIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < FLASH_DEPTH; i++) flashMem[i] <= 8'hFF;
    end else if (strobe.commit) begin
      if (strobe.op == OP_PROG) begin
        flashMem[latAddr] <= flashMem[latAddr] & latData;
      end else begin
        for (int i = 0; i < FLASH_DEPTH; i++) begin
          if (sectHit[i >> SECT_AW]) flashMem[i] <= 8'hFF;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut <= 8'h00;
    end else if (sramRd) begin
      dataOut <= sramMem[sramIdx];
    end else if (flashRd) begin
      dataOut <= strobe.busy ? {strobe.statusBit7, strobe.statusBit6, 6'b0}
                             : flashMem[flashIdx];
    end else begin
      dataOut <= 8'h00;
    end
  end

endmodule

// File: rtl/dbm_top.sv
module dbm_top
  import dbm_pkg::*;
#(
  parameter int FLASH_AW        = 10,
  parameter int SECT_AW         = 8,
  parameter int SRAM_AW         = 9,
  parameter int PROG_CYCLES     = 12,
  parameter int PROG_MAX_CYCLES = 16,
  parameter int SECT_CYCLES     = 40,
  parameter int BANK_CYCLES     = 60,
  localparam int WIDE_AW        = (FLASH_AW > SRAM_AW) ? FLASH_AW : SRAM_AW,
  localparam int BUS_AW         = (WIDE_AW > 15) ? WIDE_AW : 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BUS_AW-1:0] addr,
  input  logic [7:0]        dataIn,
  output logic [7:0]        dataOut,
  input  logic              wrStrobeN,
  input  logic              rdStrobeN,
  input  logic              flashSelN,
  input  logic              sramSelN
);

  flashStrobe_t        strobe;
  logic [FLASH_AW-1:0] latAddr;
  logic [7:0]          latData;

  dbm_ctrl #(
    .BUS_AW     (BUS_AW),
    .FLASH_AW   (FLASH_AW),
    .PROG_CYCLES(PROG_CYCLES),
    .SECT_CYCLES(SECT_CYCLES),
    .BANK_CYCLES(BANK_CYCLES)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .addr     (addr),
    .dataIn   (dataIn),
    .wrStrobeN(wrStrobeN),
    .rdStrobeN(rdStrobeN),
    .flashSelN(flashSelN),
    .sramSelN (sramSelN),
    .strobe   (strobe),
    .latAddr  (latAddr),
    .latData  (latData)
  );

  dbm_datapath #(
    .FLASH_AW(FLASH_AW),
    .SECT_AW (SECT_AW),
    .SRAM_AW (SRAM_AW)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .flashIdx (addr[FLASH_AW-1:0]),
    .sramIdx  (addr[SRAM_AW-1:0]),
    .dataIn   (dataIn),
    .wrStrobeN(wrStrobeN),
    .rdStrobeN(rdStrobeN),
    .flashSelN(flashSelN),
    .sramSelN (sramSelN),
    .strobe   (strobe),
    .latAddr  (latAddr),
    .latData  (latData),
    .dataOut  (dataOut)
  );

endmodule

// File: rtl/dbm_checker.sv
module dbm_checker
  import dbm_pkg::*;
#(
  parameter int PROG_MAX_CYCLES = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic         wrStrobeN,
  input logic         rdStrobeN,
  input logic         flashSelN,
  input logic         sramSelN,
  input logic [7:0]   dataOut,
  input flashStrobe_t strobe
);

  logic flashRd, flashWr, prevBusyRd;
  int   progCnt;

  assign flashRd = !rdStrobeN && wrStrobeN && !flashSelN && sramSelN;
  assign flashWr = !wrStrobeN && !flashSelN && sramSelN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevBusyRd <= 1'b0;
      progCnt    <= 0;
    end else begin
      prevBusyRd <= flashRd && strobe.busy;
      progCnt    <= strobe.busy ? progCnt + 1 : 0;
    end
  end

  // R1: nothing read, nothing driven
  p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobeN |=> dataOut == 8'h00);

  // R2: both selects low is a dead cycle
  p_dual_select_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!flashSelN && !sramSelN) |=> dataOut == 8'h00);

  // R9: a write during busy leaves the running operation alone
  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.busy && flashWr && !strobe.commit) |=> (strobe.busy && $stable(strobe.op)));

  // R10: program never overstays its maximum
  p_prog_max_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.busy && strobe.op == OP_PROG) |-> progCnt < PROG_MAX_CYCLES);

  // R11: status byte layout on a busy read
  p_status_low_r11: assert property (@(posedge clk) disable iff (!rstN)
    (flashRd && strobe.busy) |=>
      (dataOut[5:0] == 6'b0 && dataOut[6] == $past(strobe.statusBit6)));

  // R11: toggle bit flips between back-to-back busy reads
  p_toggle_flip_r11: assert property (@(posedge clk) disable iff (!rstN)
    (flashRd && strobe.busy && prevBusyRd) |=> dataOut[6] != $past(dataOut[6]));

  // R12: polling bit follows the operation
  p_poll_bit_r12: assert property (@(posedge clk) disable iff (!rstN)
    (flashRd && strobe.busy) |=> dataOut[7] == $past(strobe.statusBit7));

endmodule

bind dbm_top dbm_checker #(
  .PROG_MAX_CYCLES(PROG_MAX_CYCLES)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .wrStrobeN(wrStrobeN),
  .rdStrobeN(rdStrobeN),
  .flashSelN(flashSelN),
  .sramSelN (sramSelN),
  .dataOut  (dataOut),
  .strobe   (strobe)
);

// File: tb/tb_dbm_top.sv
`timescale 1ns/1ps
module tb_dbm_top;

  localparam int PROG = 12;
  localparam int SECT = 40;
  localparam int BANK = 60;
  localparam int NVEC = 12;

  // {kind[2:0], addr[14:0], data[7:0], expect[7:0], req[7:0]}
  // kind: 0 sram write, 1 sram read, 2 flash write, 3 flash read,
  //       4 dual-select write, 5 dual-select read, 6 idle then check dataOut
  localparam logic [41:0] VEC [NVEC] = '{
    {3'd0, 15'h0010, 8'h5A, 8'h00, 8'd1},   // R1
    {3'd3, 15'h0010, 8'h00, 8'hFF, 8'd1},   // R1 flash unaffected
    {3'd1, 15'h0010, 8'h00, 8'h5A, 8'd1},
    {3'd0, 15'h01FF, 8'hC3, 8'h00, 8'd1},
    {3'd1, 15'h01FF, 8'h00, 8'hC3, 8'd1},
    {3'd0, 15'h0020, 8'h11, 8'h00, 8'd2},   // R2
    {3'd4, 15'h0020, 8'h33, 8'h00, 8'd2},
    {3'd1, 15'h0020, 8'h00, 8'h11, 8'd2},
    {3'd5, 15'h0020, 8'h00, 8'h00, 8'd2},
    {3'd2, 15'h0040, 8'h00, 8'h00, 8'd4},   // R4
    {3'd3, 15'h0040, 8'h00, 8'hFF, 8'd4},
    {3'd6, 15'h0000, 8'h00, 8'h00, 8'd1}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [14:0] addr = '0;
  logic [7:0]  dataIn = '0;
  logic [7:0]  dataOut;
  logic        wrStrobeN = 1'b1, rdStrobeN = 1'b1, flashSelN = 1'b1, sramSelN = 1'b1;

  int nChecks = 0;
  int nFail   = 0;
  logic [7:0] rd;

  always #10 clk = ~clk;

  dbm_top #(
    .PROG_CYCLES(PROG), .SECT_CYCLES(SECT), .BANK_CYCLES(BANK)
  ) dut (
    .clk(clk), .rstN(rstN), .addr(addr), .dataIn(dataIn), .dataOut(dataOut),
    .wrStrobeN(wrStrobeN), .rdStrobeN(rdStrobeN),
    .flashSelN(flashSelN), .sramSelN(sramSelN)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  // Called at a falling edge; drives one bus cycle and returns at the next falling edge
  task automatic busCycle(input logic w, input logic r, input logic f, input logic s,
                          input logic [14:0] a, input logic [7:0] d);
    addr = a; dataIn = d;
    wrStrobeN = w; rdStrobeN = r; flashSelN = f; sramSelN = s;
    @(negedge clk);
    wrStrobeN = 1'b1; rdStrobeN = 1'b1; flashSelN = 1'b1; sramSelN = 1'b1;
  endtask

  task automatic sramWrite(input logic [14:0] a, input logic [7:0] d);
    busCycle(1'b0, 1'b1, 1'b1, 1'b0, a, d);
  endtask
  task automatic sramRead(input logic [14:0] a, output logic [7:0] v);
    busCycle(1'b1, 1'b0, 1'b1, 1'b0, a, 8'h00); v = dataOut;
  endtask
  task automatic flashWrite(input logic [14:0] a, input logic [7:0] d);
    busCycle(1'b0, 1'b1, 1'b0, 1'b1, a, d);
  endtask
  task automatic flashRead(input logic [14:0] a, output logic [7:0] v);
    busCycle(1'b1, 1'b0, 1'b0, 1'b1, a, 8'h00); v = dataOut;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic unlockProg(input logic [14:0] a, input logic [7:0] d);
    flashWrite(15'h5555, 8'hAA);
    flashWrite(15'h2AAA, 8'h55);
    flashWrite(15'h5555, 8'hA0);
    flashWrite(a, d);
  endtask

  task automatic eraseSeq(input logic [14:0] a, input logic [7:0] d);
    flashWrite(15'h5555, 8'hAA);
    flashWrite(15'h2AAA, 8'h55);
    flashWrite(15'h5555, 8'h80);
    flashWrite(15'h5555, 8'hAA);
    flashWrite(15'h2AAA, 8'h55);
    flashWrite(a, d);
  endtask

  // Reads status every cycle for the whole busy window (R10, R11, R12)
  task automatic pollStatus(input string tag, input int dur, input logic b7);
    logic [7:0] v;
    for (int k = 0; k < dur; k++) begin
      flashRead(15'h0000, v);
      check(tag, v, {b7, k[0], 6'b0});
    end
  endtask

  initial begin
    #(20 * 150000);
    nFail++;
    $display("FAIL watchdog actual timeout expected completion");
    finishRun();
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R13 reset state
    check("R13 dataOut after reset", dataOut, 8'h00);
    flashRead(15'h0000, rd); check("R13 erased flash low", rd, 8'hFF);
    flashRead(15'h03FF, rd); check("R13 erased flash high", rd, 8'hFF);

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      logic [2:0]  k;
      logic [14:0] a;
      logic [7:0]  d, e, q;
      k = VEC[i][41:39]; a = VEC[i][38:24]; d = VEC[i][23:16];
      e = VEC[i][15:8];  q = VEC[i][7:0];
      case (k)
        3'd0: sramWrite(a, d);
        3'd1: begin sramRead(a, rd); check($sformatf("R%0d vector %0d", q, i), rd, e); end
        3'd2: flashWrite(a, d);
        3'd3: begin flashRead(a, rd); check($sformatf("R%0d vector %0d", q, i), rd, e); end
        3'd4: busCycle(1'b0, 1'b1, 1'b0, 1'b0, a, d);
        3'd5: begin busCycle(1'b1, 1'b0, 1'b0, 1'b0, a, 8'h00);
                    check($sformatf("R%0d vector %0d", q, i), dataOut, e); end
        default: begin idle(1); check($sformatf("R%0d vector %0d", q, i), dataOut, e); end
      endcase
    end

    // R5 R10 R11 R12: program, exact busy window, then data
    unlockProg(15'h0300, 8'h3C);
    pollStatus("R11 program status", PROG, 1'b1);
    flashRead(15'h0300, rd); check("R10 data right after window", rd, 8'h3C);
    unlockProg(15'h0300, 8'hF0);
    idle(PROG + 1);
    flashRead(15'h0300, rd); check("R5 program ANDs old data", rd, 8'h30);

    // R3: SRAM during busy, and on the completion edge
    unlockProg(15'h0310, 8'h81);
    sramWrite(15'h0100, 8'h99);
    sramRead(15'h0100, rd); check("R3 sram read while busy", rd, 8'h99);
    idle(PROG - 3);
    sramWrite(15'h0101, 8'h77);  // lands on the commit edge
    sramRead(15'h0101, rd); check("R3 sram write on commit edge", rd, 8'h77);
    flashRead(15'h0310, rd); check("R3 program completes alongside", rd, 8'h81);

    // R9: a full sequence inside a busy window is ignored
    unlockProg(15'h0320, 8'h0F);
    unlockProg(15'h0321, 8'h00);
    idle(PROG);
    flashRead(15'h0321, rd); check("R9 busy-time program ignored", rd, 8'hFF);
    flashRead(15'h0320, rd); check("R9 running program intact", rd, 8'h0F);

    // R8: broken sequences start nothing
    flashWrite(15'h5555, 8'hAA);
    flashWrite(15'h2AAA, 8'h55);
    flashWrite(15'h5555, 8'h77);
    flashWrite(15'h5555, 8'hA0);
    flashWrite(15'h0330, 8'h00);
    flashRead(15'h0330, rd); check("R8 broken program sequence", rd, 8'hFF);
    flashWrite(15'h5555, 8'hAA);
    flashWrite(15'h2AAA, 8'h55);
    flashWrite(15'h5555, 8'h80);
    flashWrite(15'h5555, 8'hAA);
    flashWrite(15'h2AAA, 8'h12);
    flashWrite(15'h2AAA, 8'h55);
    flashWrite(15'h0300, 8'h30);
    flashRead(15'h0300, rd); check("R8 broken erase sequence", rd, 8'h30);

    // R6: sector erase hits only its own sector
    unlockProg(15'h0200, 8'h00);
    idle(PROG + 1);
    eraseSeq(15'h0250, 8'h30);
    pollStatus("R6 sector erase status", SECT, 1'b0);
    flashRead(15'h0200, rd); check("R6 sector byte erased", rd, 8'hFF);
    flashRead(15'h0300, rd); check("R6 other sector kept", rd, 8'h30);
    flashRead(15'h0310, rd); check("R6 other sector kept 2", rd, 8'h81);

    // R7: bank erase only at the command address
    eraseSeq(15'h1234, 8'h10);
    flashRead(15'h0300, rd); check("R7 misplaced bank command", rd, 8'h30);
    eraseSeq(15'h5555, 8'h10);
    pollStatus("R7 bank erase status", BANK, 1'b0);
    flashRead(15'h0300, rd); check("R7 bank erased", rd, 8'hFF);
    flashRead(15'h0320, rd); check("R7 bank erased 2", rd, 8'hFF);
    sramRead(15'h0010, rd);  check("R7 sram untouched", rd, 8'h5A);

    finishRun();
  end

endmodule